// File: doc/BRIEF.md
# Calendar Real-Time Clock with Countdown Stopwatch

This core keeps wall-clock time for a chip that has a slow 32.768 kHz reference. The reference reaches the block as a single-cycle enable, `tick_32k`, in the fast system clock domain. A binary prescaler turns those enables into one tick per second. That tick steps a chain of counters: seconds, then minutes, then hours, then a free-running day count that spans 32,768 days.

Software uses a small write/read register port to do four things. It loads the time. It programs a time-of-day alarm and a day-plus-time alarm. It loads a one-second-resolution countdown stopwatch. It chooses which events may interrupt. Seven sticky status flags record the events: second, minute, hour and day rollovers, the stopwatch reaching zero, and the two alarm matches. `irq` is a level output that combines the flags that are enabled. `wake` is a one-cycle pulse, raised whenever an enabled event fires, for power-management logic outside the block.

Reads are combinational and have no side effects. Writes take effect at the clock edge on which `reg_wr` is high. The register port is a plain control path with no handshake, so it never applies back-pressure.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time, both alarms, the stopwatch, the enable register and the status register read zero, and `irq` and `wake` are low.
- R2: The seconds count advances once for every 2^PRESC_W cycles with `tick_32k` high. Cycles with `tick_32k` low do not count, and the time never changes without such a tick or a write.
- R3: Seconds run 0..59, minutes 0..59 and hours 0..23. Each stage wraps to 0 and carries one count into the next stage.
- R4: The day field wraps from 32767 to 0.
- R5: Writing address 0 loads the time as {day[31:17], hour[16:12], minute[11:6], second[5:0]} and clears the prescaler. The next second therefore arrives a full 2^PRESC_W enables after the write.
- R6: Address 5 is the status register. Its bits 0, 1, 2 and 3 set when a second passes, when the seconds wrap, when the minutes wrap and when the hours wrap.
- R7: Address 1 holds a time-of-day alarm in bits [16:0], laid out like the time. Status bit 5 sets on the second in which the new hour, minute and second equal it, whatever the day.
- R8: Address 2 holds a full alarm in the same layout as the time. Status bit 6 sets only when the new day also matches.
- R9: Address 3 loads the stopwatch. It counts down by one per second only while enable bit 4 is set, and it holds its value while that bit is clear. On the step from 1 to 0, status bit 4 sets. At 0 the stopwatch stays at 0.
- R10: A write to address 5 clears each status bit whose data bit is 1 and leaves the others. If an event and a clear meet in the same cycle, the event wins.
- R11: Address 4 holds the enable bits, in the same positions as the status bits. `irq` is high exactly while some status bit and its enable bit are both set.
- R12: `wake` is high for one cycle, the cycle after each edge on which an enabled event fires, and it never rises for a disabled event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable per period of the 32.768 kHz reference |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 time, 1 time-of-day alarm, 2 full alarm, 3 stopwatch, 4 enables, 5 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt: OR of enabled status bits |
| wake | output | 1 | One-cycle pulse on any enabled event |

## Verification
A faulty carry or a wrong limit in the chain shows at the time register on the second the stage wraps. With a short prescaler that is a few cycles after the time has been loaded near the boundary, and the sticky status bits keep a record of which rollover fired. A wrong alarm comparison shows up as a status bit that is missing or extra on the matching second, or on a second next to it. A stopwatch that decrements while disabled, or that goes past zero, changes its readback within one second. A prescaler that is not cleared on a time write moves the first second earlier, which shows in the time readback before 2^PRESC_W enables have passed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 15;
  localparam int TOD_W = HR_W + MIN_W + SEC_W;
  localparam int TIME_W = DAY_W + TOD_W;

  localparam int NUM_EV = 7;
  localparam int EV_SEC = 0;
  localparam int EV_MIN = 1;
  localparam int EV_HR  = 2;
  localparam int EV_DAY = 3;
  localparam int EV_SW  = 4;
  localparam int EV_ALA = 5;
  localparam int EV_ALB = 6;

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hour;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } rtc_time_t;

  typedef enum logic [2:0] {
    ADDR_TIME  = 3'd0,
    ADDR_ALM_T = 3'd1,
    ADDR_ALM_F = 3'd2,
    ADDR_SW    = 3'd3,
    ADDR_IEN   = 3'd4,
    ADDR_STAT  = 3'd5
  } rtc_addr_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] cnt;

  assign tick = en && !clr && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_wrap_ctr.sv
module rtc_wrap_ctr #(
  parameter int W = 6,
  parameter logic [W-1:0] TOP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  // A value loaded above TOP also wraps on the next step.
  assign wrap = step && (value >= TOP);

  always_comb begin
    if (!step)     nxt = value;
    else if (wrap) nxt = '0;
    else           nxt = value + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else           value <= nxt;
  end
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] value,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  assign expire = run && tick && !load && (value == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            value <= '0;
    else if (load)                         value <= load_val;
    else if (run && tick && value != '0)   value <= value - 1'b1;
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic         en_wr,
  input  logic [N-1:0] en_val,
  output logic [N-1:0] status,
  output logic [N-1:0] enable,
  output logic         irq,
  output logic         wake
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;
  assign irq     = |(status & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      wake   <= 1'b0;
    end else begin
      // An event in the same cycle overrides the clear.
      status <= (status & ~clr_eff) | set_ev;
      wake   <= |(set_ev & enable);
      if (en_wr) enable <= en_val;
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int PRESC_W = 15,
  parameter int SW_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_32k,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        wake
);
  localparam logic [SEC_W-1:0] SEC_TOP = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_TOP = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_TOP  = HR_W'(23);
  localparam logic [DAY_W-1:0] DAY_TOP = '1;

  logic wr_time, wr_alm_t, wr_alm_f, wr_sw, wr_ien, wr_stat;
  assign wr_time  = reg_wr && (reg_addr == ADDR_TIME);
  assign wr_alm_t = reg_wr && (reg_addr == ADDR_ALM_T);
  assign wr_alm_f = reg_wr && (reg_addr == ADDR_ALM_F);
  assign wr_sw    = reg_wr && (reg_addr == ADDR_SW);
  assign wr_ien   = reg_wr && (reg_addr == ADDR_IEN);
  assign wr_stat  = reg_wr && (reg_addr == ADDR_STAT);

  rtc_time_t  load_t;
  assign load_t = rtc_time_t'(reg_wdata[TIME_W-1:0]);

  logic sec_tick;
  rtc_prescaler #(.W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(wr_time), .en(tick_32k), .tick(sec_tick)
  );

  rtc_time_t time_q, time_nx;
  logic sec_wrap, min_wrap, hr_wrap, day_wrap;

  rtc_wrap_ctr #(.W(SEC_W), .TOP(SEC_TOP)) u_sec (
    .clk(clk), .rst_n(rst_n), .load(wr_time), .load_val(load_t.sec),
    .step(sec_tick), .value(time_q.sec), .nxt(time_nx.sec), .wrap(sec_wrap)
  );
  rtc_wrap_ctr #(.W(MIN_W), .TOP(MIN_TOP)) u_min (
    .clk(clk), .rst_n(rst_n), .load(wr_time), .load_val(load_t.min),
    .step(sec_wrap), .value(time_q.min), .nxt(time_nx.min), .wrap(min_wrap)
  );
  rtc_wrap_ctr #(.W(HR_W), .TOP(HR_TOP)) u_hr (
    .clk(clk), .rst_n(rst_n), .load(wr_time), .load_val(load_t.hour),
    .step(min_wrap), .value(time_q.hour), .nxt(time_nx.hour), .wrap(hr_wrap)
  );
  rtc_wrap_ctr #(.W(DAY_W), .TOP(DAY_TOP)) u_day (
    .clk(clk), .rst_n(rst_n), .load(wr_time), .load_val(load_t.day),
    .step(hr_wrap), .value(time_q.day), .nxt(time_nx.day), .wrap(day_wrap)
  );

  // Alarm registers
  logic [TOD_W-1:0]  alm_tod;
  logic [TIME_W-1:0] alm_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_tod  <= '0;
      alm_full <= '0;
    end else begin
      if (wr_alm_t) alm_tod  <= reg_wdata[TOD_W-1:0];
      if (wr_alm_f) alm_full <= reg_wdata[TIME_W-1:0];
    end
  end

  // Alarms compare the time that this second tick is about to load.
  logic hit_tod, hit_full;
  assign hit_tod  = sec_tick && (time_nx[TOD_W-1:0] == alm_tod);
  assign hit_full = sec_tick && (time_nx == alm_full);

  logic [NUM_EV-1:0] status, enable, set_ev;
  logic [SW_W-1:0]   sw_val;
  logic              sw_expire;

  rtc_stopwatch #(.W(SW_W)) u_sw (
    .clk(clk), .rst_n(rst_n), .load(wr_sw), .load_val(reg_wdata[SW_W-1:0]),
    .run(enable[EV_SW]), .tick(sec_tick), .value(sw_val), .expire(sw_expire)
  );

  always_comb begin
    set_ev         = '0;
    set_ev[EV_SEC] = sec_tick;
    set_ev[EV_MIN] = sec_wrap;
    set_ev[EV_HR]  = min_wrap;
    set_ev[EV_DAY] = hr_wrap;
    set_ev[EV_SW]  = sw_expire;
    set_ev[EV_ALA] = hit_tod;
    set_ev[EV_ALB] = hit_full;
  end

  rtc_irq_ctrl #(.N(NUM_EV)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev),
    .clr_wr(wr_stat), .clr_mask(reg_wdata[NUM_EV-1:0]),
    .en_wr(wr_ien), .en_val(reg_wdata[NUM_EV-1:0]),
    .status(status), .enable(enable), .irq(irq), .wake(wake)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_TIME:  reg_rdata[TIME_W-1:0] = time_q;
      ADDR_ALM_T: reg_rdata[TOD_W-1:0]  = alm_tod;
      ADDR_ALM_F: reg_rdata[TIME_W-1:0] = alm_full;
      ADDR_SW:    reg_rdata[SW_W-1:0]   = sw_val;
      ADDR_IEN:   reg_rdata[NUM_EV-1:0] = enable;
      ADDR_STAT:  reg_rdata[NUM_EV-1:0] = status;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker #(
  parameter int SW_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [2:0]      reg_addr,
  input logic [31:0]     reg_wdata,
  input logic [31:0]     time_v,
  input logic            sec_tick,
  input logic            day_wrap,
  input logic [6:0]      status,
  input logic [SW_W-1:0] sw_val,
  input logic            irq,
  input logic            wake
);
  logic wr_time, wr_stat, wr_sw;
  assign wr_time = reg_wr && (reg_addr == 3'd0);
  assign wr_sw   = reg_wr && (reg_addr == 3'd3);
  assign wr_stat = reg_wr && (reg_addr == 3'd5);

  assert_time_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_time) |=> $stable(time_v));

  assert_day_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_time && time_v[16:12] == 5'd23 && time_v[11:6] == 6'd59
     && time_v[5:0] == 6'd59)
    |=> (time_v[31:17] == 15'($past(time_v[31:17]) + 15'd1)));

  assert_day_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (day_wrap && !wr_time) |=> (time_v[31:17] == 15'd0));

  assert_time_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time |=> (time_v == $past(reg_wdata)));

  assert_sw_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sw |=> (sw_val <= $past(sw_val)));

  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((status & $past(status)) == $past(status)));

  assert_wake_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq);
endmodule

bind rtc_calendar_core rtc_calendar_checker #(.SW_W(SW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .time_v(time_q), .sec_tick(sec_tick),
  .day_wrap(day_wrap), .status(status), .sw_val(sw_val),
  .irq(irq), .wake(wake)
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
  localparam int PW  = 2;
  localparam int TPS = 1 << PW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_32k = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, wake;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_core #(.PRESC_W(PW), .SW_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .wake(wake)
  );

  function automatic logic [31:0] tm(int d, int h, int m, int s);
    return {15'(d), 5'(h), 6'(m), 6'(s)};
  endfunction

  typedef struct packed {
    logic [31:0] start;
    logic [7:0]  secs;
    logic [31:0] exp_t;
    logic [6:0]  exp_st;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{tm(0,0,0,0),       8'd1, tm(0,0,0,1),   7'h01},
    '{tm(0,0,0,59),      8'd1, tm(0,0,1,0),   7'h03},
    '{tm(0,0,59,59),     8'd1, tm(0,1,0,0),   7'h07},
    '{tm(5,23,59,59),    8'd1, tm(6,0,0,0),   7'h0F},
    '{tm(32767,23,59,59),8'd1, tm(0,0,0,0),   7'h0F},
    '{tm(3,1,2,3),       8'd3, tm(3,1,2,6),   7'h01},
    '{tm(1,22,59,58),    8'd3, tm(1,23,0,1),  7'h07}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic run_secs(int n);
    tick_32k = 1'b1;
    repeat (n * TPS) @(negedge clk);
    tick_32k = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int wk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 time", v, 0);
    rd(3'd5, v); check("R1 status", v, 0);
    rd(3'd4, v); check("R1 enable", v, 0);
    rd(3'd3, v); check("R1 stopwatch", v, 0);
    rd(3'd1, v); check("R1 alarm tod", v, 0);
    check("R1 irq/wake", {30'd0, irq, wake}, 0);

    // Unreachable alarms for the table walk (hour 31)
    wr(3'd1, 32'h1F << 12);
    wr(3'd2, 32'hFFFF_FFFF);

    // Table of rollover vectors: R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      wr(3'd5, 32'h7F);
      wr(3'd0, VECS[i].start);
      run_secs(int'(VECS[i].secs));
      rd(3'd0, v); check("R3/R4 time vector", v, VECS[i].exp_t);
      rd(3'd5, v); check("R6 status vector", v, {25'd0, VECS[i].exp_st});
    end

    // R2: no enables means no change, then half-rate enables
    wr(3'd0, tm(2,3,4,5));
    repeat (20) @(negedge clk);
    rd(3'd0, v); check("R2 idle hold", v, tm(2,3,4,5));
    for (int i = 0; i < 6; i++) begin
      tick_32k = (i % 2 == 0);
      @(negedge clk);
    end
    rd(3'd0, v); check("R2 three enables", v, tm(2,3,4,5));
    for (int i = 6; i < 8; i++) begin
      tick_32k = (i % 2 == 0);
      @(negedge clk);
    end
    tick_32k = 1'b0;
    rd(3'd0, v); check("R2 four enables", v, tm(2,3,4,6));

    // R5: a mid-second write restarts the prescaler
    tick_32k = 1'b1;
    repeat (2) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = tm(0,0,0,10);
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (TPS - 1) @(negedge clk);
    rd(3'd0, v); check("R5 no early second", v, tm(0,0,0,10));
    @(negedge clk);
    tick_32k = 1'b0;
    rd(3'd0, v); check("R5 second after full count", v, tm(0,0,0,11));

    // R7 / R8 alarms
    wr(3'd1, tm(0,10,20,30));
    wr(3'd2, tm(9,10,20,30));
    wr(3'd0, tm(7,10,20,28));
    wr(3'd5, 32'h7F);
    run_secs(1);
    rd(3'd5, v); check("R7 no match one second early", v & 32'h60, 0);
    run_secs(1);
    rd(3'd5, v); check("R7 tod alarm fires, R8 day mismatch", v & 32'h60, 32'h20);
    wr(3'd0, tm(9,10,20,28));
    wr(3'd5, 32'h7F);
    run_secs(2);
    rd(3'd5, v); check("R8 full alarm fires", v & 32'h60, 32'h60);

    // R9 stopwatch
    wr(3'd4, 32'h10);
    wr(3'd3, 32'd3);
    wr(3'd5, 32'h7F);
    run_secs(2);
    rd(3'd3, v); check("R9 count down", v, 1);
    rd(3'd5, v); check("R9 not expired", v & 32'h10, 0);
    run_secs(1);
    rd(3'd3, v); check("R9 reached zero", v, 0);
    rd(3'd5, v); check("R9 expiry flag", v & 32'h10, 32'h10);
    check("R11 irq from stopwatch", {31'd0, irq}, 1);
    run_secs(2);
    rd(3'd3, v); check("R9 holds at zero", v, 0);
    wr(3'd4, 32'h00);
    wr(3'd3, 32'd5);
    run_secs(2);
    rd(3'd3, v); check("R9 disabled holds", v, 5);

    // R10 write-one-to-clear keeps other bits
    wr(3'd5, 32'h7F);
    wr(3'd0, tm(0,0,0,59));
    run_secs(1);
    wr(3'd5, 32'h01);
    rd(3'd5, v); check("R10 partial clear", v, 32'h02);
    // R10 event beats clear in the same cycle
    wr(3'd5, 32'h7F);
    wr(3'd0, tm(0,0,1,0));
    tick_32k = 1'b1;
    repeat (TPS - 1) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h01;
    @(negedge clk);
    reg_wr = 1'b0; tick_32k = 1'b0;
    rd(3'd5, v); check("R10 set wins", v & 32'h01, 1);

    // R11 irq gating
    wr(3'd4, 32'h00);
    check("R11 disabled flag no irq", {31'd0, irq}, 0);
    wr(3'd4, 32'h01);
    check("R11 enabled flag irq", {31'd0, irq}, 1);
    wr(3'd5, 32'h7F);
    check("R11 cleared no irq", {31'd0, irq}, 0);

    // R12 wake pulses
    wk = 0;
    tick_32k = 1'b1;
    for (int i = 0; i < 2 * TPS; i++) begin
      @(negedge clk);
      if (wake) wk++;
    end
    tick_32k = 1'b0;
    check("R12 one pulse per enabled second", wk, 2);
    wr(3'd4, 32'h00);
    wk = 0;
    tick_32k = 1'b1;
    for (int i = 0; i < 2 * TPS; i++) begin
      @(negedge clk);
      if (wake) wk++;
    end
    tick_32k = 1'b0;
    check("R12 no wake when disabled", wk, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule